// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block puts a clocked interface in front of an external asynchronous static RAM of 2^19 words by 8 bits. A client raises a start strobe together with a read/write select, an address and a write word. When the controller is idle it takes the request on that clock edge and then drives the memory's address lines, its active-low chip-enable, output-enable and write-enable lines, and its shared data bus. The FSM gives each phase of an access one whole clock state. At a 50 MHz clock this keeps the memory's access time, write-pulse width and data setup time within limits.

Every access, read or write, occupies two busy cycles, and `ready` is low during both. Read data is returned in two forms. One is a registered copy that holds its value until the next read completes. The other is a direct tap of the data bus, which shows the memory's output while output-enable is low. The data bus is bidirectional. The controller drives it only while a write is in progress and releases it in every other state, so it never drives against the memory.

Top module: `sram_ctrl_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `ready` is 1, `mem_oe_n` and `mem_we_n` are 1, the controller releases `mem_dq`, and `mem_ce_n` is 0. `mem_ce_n` stays 0 at all times.
- R2: A request is accepted on a rising edge where `start` and `ready` are both 1. `rd_nwr` = 1 selects a read and 0 selects a write. `ready` is 0 for exactly the two cycles that follow an accept and is 1 again on the third.
- R3: `start` is ignored while `ready` is 0. It starts no access, changes neither the address bus nor the memory contents, and does not lengthen the busy period.
- R4: A read holds `mem_oe_n` low for exactly the two cycles after the accept and keeps `mem_we_n` high throughout.
- R5: At the end of the second read cycle, `rdata_q` loads the word on the data bus. It keeps that value through later writes and idle cycles until the next read completes.
- R6: A write holds `mem_we_n` low for exactly the first cycle after the accept and high in the second, and keeps `mem_oe_n` high throughout.
- R7: The controller drives `mem_dq` only during the two write cycles. In every other state it releases the bus, and it never drives while `mem_oe_n` is low.
- R8: `mem_oe_n` and `mem_we_n` are never low in the same cycle.
- R9: `mem_addr` takes the accepted address on the accept edge and stays unchanged until the next accept.
- R10: During both write cycles `mem_dq` carries the accepted write word, so the word is on the bus before `mem_we_n` rises and is still there for one cycle after.
- R11: `rdata_raw` is a direct view of the data bus. During a read it shows the word stored at the addressed location, in both busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, taken only when `ready` is 1 |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Word to store on a write |
| ready | output | 1 | 1 when a new request can be accepted |
| rdata_q | output | DATA_W | Word captured by the last completed read |
| rdata_raw | output | DATA_W | Unregistered view of the memory data bus |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The bench writes every location of a 64-word configuration and reads all of them back, in the opposite order, with accesses issued back to back. A controller that shortened the read window, or captured data one cycle late, would return the wrong word or a released bus. During some reads the bench holds `start` high with a different address, the opposite select and different data, then checks that the address bus does not move and that the target location keeps its contents later. A controller that queued or executed such a request would corrupt that location or stay busy too long. Each write is checked for a one-cycle write-enable pulse, for data on the bus before and after the rising edge, and for a released bus once the write ends. Each write also checks that the read register has not changed. A driver left on too long, or a register loaded on a write, would show up here.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and control bundle for the SRAM controller.
// Assumes one clock domain; every field of the bundle is registered.
package sram_ctrl_pkg;

    // FSM states; each memory phase owns one whole clock state
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OE    = 3'd1,
        ST_RD_CAP   = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } sram_state_e;

    // Registered control lines produced by the FSM
    typedef struct packed {
        logic ready;
        logic oe_n;
        logic we_n;
        logic drive;
    } sram_ctl_t;

    localparam sram_ctl_t CTL_IDLE = '{ready: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/sram_ctrl_fsm.sv
// Module: control FSM. It sequences two states per read and two per write.
// The control lines are decoded from the next state and then registered,
// so the memory strobes come straight from flops and cannot glitch.
// Assumes a clock period longer than the memory access time.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      rd_nwr,
    output sram_ctl_t ctl,
    output logic      accept,
    output logic      capture
);

    sram_state_e state_q;
    sram_state_e state_d;
    sram_ctl_t   ctl_d;

    // A request is taken only while the controller is idle
    assign accept  = start && ctl.ready;
    // The read register loads on the edge that leaves the capture state
    assign capture = (state_q == ST_RD_CAP);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = rd_nwr ? ST_RD_OE : ST_WR_PULSE;
            ST_RD_OE:    state_d = ST_RD_CAP;
            ST_RD_CAP:   state_d = ST_IDLE;
            ST_WR_PULSE: state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Decode the control lines for the state about to be entered
    always_comb begin
        ctl_d.ready = (state_d == ST_IDLE);
        ctl_d.oe_n  = !((state_d == ST_RD_OE) || (state_d == ST_RD_CAP));
        ctl_d.we_n  = !(state_d == ST_WR_PULSE);
        ctl_d.drive = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    end

    // State and control registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl     <= CTL_IDLE;
        end else begin
            state_q <= state_d;
            ctl     <= ctl_d;
        end
    end

endmodule

// File: rtl/sram_ctrl_dp.sv
// Module: datapath. It has one address register and one register per data
// direction. Address and write word load on accept. The read word loads
// on capture and is otherwise held.
module sram_ctrl_dp #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Request registers: hold address and write word for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Read register: samples the data bus at the end of a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctrl_pad.sv
// Module: tri-state buffer, one per data bit. It drives the bus only while
// drive is high and passes the bus value back unregistered at all times.
module sram_ctrl_pad #(
    parameter int DATA_W = 8
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din,
    inout  tri   [DATA_W-1:0] io
);

    // One buffer per bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign io[i]  = drive ? dout[i] : 1'bz;
        assign din[i] = io[i];
    end

endmodule

// File: rtl/sram_ctrl_top.sv
// Module: top of the SRAM controller. It gives a clocked start/ready
// interface to an asynchronous SRAM. Chip enable is held active.
// Assumes a clock period of at least the memory access time and the
// write pulse width (20 ns covers both).
module sram_ctrl_top
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] rdata_raw,
    output logic [ADDR_W-1:0] mem_addr,
    inout  tri   [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    sram_ctl_t         ctl;
    logic              accept;
    logic              capture;
    logic              dq_drive;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] bus_in;

    sram_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_nwr  (rd_nwr),
        .ctl     (ctl),
        .accept  (accept),
        .capture (capture)
    );

    sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .capture (capture),
        .addr    (addr),
        .wdata   (wdata),
        .bus_in  (bus_in),
        .addr_q  (mem_addr),
        .wdata_q (wdata_q),
        .rdata_q (rdata_q)
    );

    sram_ctrl_pad #(.DATA_W(DATA_W)) u_pad (
        .drive (dq_drive),
        .dout  (wdata_q),
        .din   (bus_in),
        .io    (mem_dq)
    );

    // Port mapping of the registered control bundle
    assign dq_drive  = ctl.drive;
    assign ready     = ctl.ready;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_ce_n  = 1'b0;
    assign rdata_raw = bus_in;

endmodule

// File: rtl/sram_ctrl_chk.sv
// Module: protocol checker bound to sram_ctrl_top. It watches the strobes,
// the bus driver and the handshake.
module sram_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              dq_drive,
    input logic [ADDR_W-1:0] mem_addr
);

    AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_oe_n && !mem_we_n)); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) dq_drive |-> mem_oe_n); // R7
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_we_n) |=> $rose(mem_we_n)); // R6
    AST_DATA_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> dq_drive); // R10
    AST_OE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_oe_n) |=> !mem_oe_n ##1 mem_oe_n); // R4
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && ready) |=> !ready); // R2
    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |=> !ready ##1 ready); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(start && ready) |=> $stable(mem_addr)); // R9

endmodule

bind sram_ctrl_top sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .dq_drive (dq_drive),
    .mem_addr (mem_addr)
);

// File: tb/sim_sram_ctrl_top.sv
// Bench: 64-word configuration, full write sweep, reverse read sweep,
// ignored-start probes and interleaved write/read, against a behavioural SRAM.
module sim_sram_ctrl_top;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_nwr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rdata_raw;
    logic [AW-1:0] mem_addr;
    tri   [DW-1:0] dq;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic          mem_we_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] shadow [WORDS];
    logic [DW-1:0] last_rd = '0;
    logic [DW-1:0] model_mem [WORDS];

    localparam logic [DW-1:0] RELEASED = '1;

    always #5 clk = ~clk;

    sram_ctrl_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .addr(addr), .wdata(wdata), .ready(ready), .rdata_q(rdata_q),
        .rdata_raw(rdata_raw), .mem_addr(mem_addr), .mem_dq(dq),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Behavioural SRAM: drives out on read, stores on the rising write strobe
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end
    assign dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_mem[mem_addr] : 'z;
    always @(posedge mem_we_n) if (!mem_ce_n && rst_n) model_mem[mem_addr] <= dq;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + 5 + k * 11) % 251);
    endfunction

    // One access starting at a negedge with ready high. probe keeps start high
    // while busy with a different request, which must be ignored.
    task automatic do_op(input bit rd, input int a, input logic [DW-1:0] d, input bit probe);
        start = 1'b1; rd_nwr = rd; addr = AW'(a); wdata = d;
        @(negedge clk);
        chk(!ready, "R2 busy c1", ready, 0);
        chk(mem_addr == AW'(a), "R9 addr", mem_addr, a);
        if (probe) begin
            start = 1'b1; rd_nwr = 1'b0; addr = ~AW'(a); wdata = ~d;
        end else start = 1'b0;
        if (rd) begin
            chk(!mem_oe_n && mem_we_n, "R4 oe c1", {mem_oe_n, mem_we_n}, 2'b01);
            chk(rdata_raw == shadow[a], "R11 raw c1", rdata_raw, shadow[a]);
        end else begin
            chk(!mem_we_n && mem_oe_n, "R6 we c1", {mem_oe_n, mem_we_n}, 2'b10);
            chk(dq == d, "R10 data c1", dq, d);
        end
        @(negedge clk);
        chk(!ready, "R2 busy c2", ready, 0);
        chk(mem_addr == AW'(a), "R3 addr held", mem_addr, a);
        if (rd) begin
            chk(!mem_oe_n && mem_we_n, "R4 oe c2", {mem_oe_n, mem_we_n}, 2'b01);
            chk(rdata_raw == shadow[a], "R11 raw c2", rdata_raw, shadow[a]);
        end else begin
            chk(mem_we_n && mem_oe_n, "R6 we c2", {mem_oe_n, mem_we_n}, 2'b11);
            chk(dq == d, "R10 data c2", dq, d);
        end
        @(negedge clk);
        start = 1'b0;
        chk(ready, "R2 ready back", ready, 1);
        chk(mem_oe_n && mem_we_n, "R8 idle strobes", {mem_oe_n, mem_we_n}, 2'b11);
        chk(dq == RELEASED, "R7 bus released", dq, RELEASED);
        if (rd) begin
            last_rd = shadow[a];
            chk(rdata_q == shadow[a], "R5 rdata_q", rdata_q, shadow[a]);
        end else begin
            shadow[a] = d;
            chk(rdata_q == last_rd, "R5 rdata_q held over write", rdata_q, last_rd);
        end
        if (probe) begin
            @(negedge clk);
            chk(ready && mem_oe_n && mem_we_n, "R3 no extra access", {ready, mem_oe_n, mem_we_n}, 3'b111);
            chk(mem_addr == AW'(a), "R3 addr unchanged", mem_addr, a);
            chk(rdata_q == last_rd, "R5 rdata_q held idle", rdata_q, last_rd);
        end
    endtask

    // Watchdog: ends a hung run as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            shadow[i] = '0;
            model_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: state held under reset
        chk(ready && mem_oe_n && mem_we_n, "R1 reset strobes", {ready, mem_oe_n, mem_we_n}, 3'b111);
        chk(dq == RELEASED, "R1 reset bus", dq, RELEASED);
        chk(!mem_ce_n, "R1 ce low", mem_ce_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_oe_n && mem_we_n && !mem_ce_n, "R1 after reset", {ready, mem_oe_n, mem_we_n, mem_ce_n}, 4'b1110);
        // full write sweep, back to back
        for (int a = 0; a < WORDS; a++) do_op(1'b0, a, pat(a, 0), 1'b0);
        // reverse read sweep, with ignored probes (R3)
        for (int a = WORDS - 1; a >= 0; a--) do_op(1'b1, a, 8'h00, (a % 4) == 0);
        // interleaved write then read on odd addresses
        for (int a = 1; a < WORDS; a += 2) begin
            do_op(1'b0, a, pat(a, 3), 1'b0);
            do_op(1'b1, a, 8'h00, 1'b0);
        end
        // final read sweep: probes must not have altered any word (R3)
        for (int a = 0; a < WORDS; a++) do_op(1'b1, a, 8'h00, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule